// File: doc/BRIEF.md
# PLL Reconfiguration Completion Tracker

This block sits between a reconfiguration controller and a reconfigurable PLL. The controller issues a one-cycle config-update request. The block watches the scan-done signal that comes back from the PLL and turns it into a clean busy flag and a single-cycle completion pulse. The parameter `PULSE_STYLE` picks how the PLL signals completion:

- **Level style (0):** scan-done idles high. It falls once the PLL has taken the update, and it comes back high when every pending update is finished.
- **Pulse style (1):** scan-done idles low. It is high for exactly one cycle at completion.

Whichever style is chosen, the controller sees the same busy flag and the same done pulse.

The block is the only source of the PLL reset. That output follows the block's reset-request input and nothing else. A reset request also abandons any update that is being tracked.

A small readback stage forwards scan-chain data from the PLL. It marks that data as valid only while the reconfig request is asserted, because the data means nothing at other times.

Top module: `pll_update_tracker`

## Requirements
- R1: While `rst_n` is low, and after it has risen, until the first stimulus: `busy_o`, `done_pulse_o`, `pll_rst_o`, `rd_valid_o` and `rd_data_o` are 0.
- R2: `busy_o` rises in the cycle after a clock edge that samples `cfg_update_i`=1 with `pll_rst_req_i`=0 while idle.
- R3: In level style (`PULSE_STYLE`=0), scan-done samples that are high before the first low sample after the update do not complete it, and `busy_o` stays 1.
- R4: In level style, once scan-done has been sampled low, the first edge that samples it high clears `busy_o` and raises `done_pulse_o` in the following cycle.
- R5: In pulse style (`PULSE_STYLE`=1), the first edge after the update that samples scan-done high clears `busy_o` and raises `done_pulse_o` in the following cycle.
- R6: `done_pulse_o` is high for exactly one cycle, only when `busy_o` falls on completion. Scan-done activity while idle yields no pulse.
- R7: `done_level_o` equals the inverse of `busy_o` in level style and equals `done_pulse_o` in pulse style.
- R8: `pll_rst_o` equals `pll_rst_req_i` as sampled at the previous clock edge. No other input affects it.
- R9: An edge that samples `pll_rst_req_i`=1 returns the tracker to idle: `busy_o` is 0 and no done pulse follows. A config update sampled together with the reset request is ignored.
- R10: `rd_valid_o` equals `rcfg_req_i` from the previous edge. `rd_data_o` equals `scan_rd_i` AND `rcfg_req_i` from the previous edge, so it is 0 when the request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_update_i | input | 1 | One-cycle update request issued by the controller |
| scan_done_i | input | 1 | Scan-done signal from the PLL |
| pll_rst_req_i | input | 1 | Request to hold the PLL in reset |
| rcfg_req_i | input | 1 | Reconfig request; qualifies the readback data |
| scan_rd_i | input | 1 | Serial readback data from the PLL scan chain |
| busy_o | output | 1 | An update is being tracked |
| done_pulse_o | output | 1 | One-cycle completion pulse |
| done_level_o | output | 1 | Completion status in the convention of the selected style |
| pll_rst_o | output | 1 | Reset output to the PLL |
| rd_valid_o | output | 1 | Readback data is meaningful |
| rd_data_o | output | 1 | Qualified readback data |

## Verification
Every registered result is due exactly one edge after the inputs that cause it:

- `busy_o` follows the update edge.
- `done_pulse_o` and the fall of `busy_o` follow the edge that samples the completing scan-done value.
- `pll_rst_o`, `rd_valid_o` and `rd_data_o` follow their inputs by one edge.

The bench changes inputs on the falling edge. At each falling edge it first compares the outputs against the inputs it drove one iteration earlier, then drives the next set. The expected busy window and done cycle are computed arithmetically from the swept scan-done delays of each run.

// File: rtl/upd_pkg.sv
package upd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_LOW  = 2'd1,
    ST_WAIT_HIGH = 2'd2
  } upd_state_e;

endpackage

// File: rtl/upd_rst_sync.sv
module upd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/upd_seq.sv
module upd_seq
  import upd_pkg::*;
#(
  parameter bit PULSE_STYLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_update_i,
  input  logic scan_done_i,
  input  logic pll_rst_req_i,
  output logic busy_o,
  output logic done_pulse_o,
  output logic pll_rst_o
);

  localparam upd_state_e START_ST = PULSE_STYLE ? ST_WAIT_HIGH : ST_WAIT_LOW;

  upd_state_e st_q, st_d;
  logic       st_en;
  logic       done_q, done_d, done_en;
  logic       prst_q, prst_en;

  // next state
  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    if (pll_rst_req_i) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (cfg_update_i) st_d = START_ST;
        end
        ST_WAIT_LOW: begin
          if (!scan_done_i) st_d = ST_WAIT_HIGH;
        end
        ST_WAIT_HIGH: begin
          if (scan_done_i) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign st_en   = (st_d != st_q);
  assign done_en = (done_d != done_q);
  assign prst_en = (pll_rst_req_i != prst_q);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      prst_q <= 1'b0;
    end else begin
      if (st_en)   st_q   <= st_d;
      if (done_en) done_q <= done_d;
      if (prst_en) prst_q <= pll_rst_req_i;
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_pulse_o = done_q;
  assign pll_rst_o    = prst_q;

endmodule

// File: rtl/upd_readback.sv
module upd_readback (
  input  logic clk,
  input  logic rst_n,
  input  logic rcfg_req_i,
  input  logic scan_rd_i,
  output logic rd_valid_o,
  output logic rd_data_o
);

  logic vld_q, dat_q, dat_d;
  logic vld_en, dat_en;

  assign dat_d  = scan_rd_i & rcfg_req_i;
  assign vld_en = (rcfg_req_i != vld_q);
  assign dat_en = (dat_d != dat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= 1'b0;
    end else begin
      if (vld_en) vld_q <= rcfg_req_i;
      if (dat_en) dat_q <= dat_d;
    end
  end

  assign rd_valid_o = vld_q;
  assign rd_data_o  = dat_q;

endmodule

// File: rtl/pll_update_tracker.sv
module pll_update_tracker #(
  parameter bit PULSE_STYLE = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_update_i,
  input  logic scan_done_i,
  input  logic pll_rst_req_i,
  input  logic rcfg_req_i,
  input  logic scan_rd_i,
  output logic busy_o,
  output logic done_pulse_o,
  output logic done_level_o,
  output logic pll_rst_o,
  output logic rd_valid_o,
  output logic rd_data_o
);

  logic srst_n;

  upd_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  upd_seq #(.PULSE_STYLE(PULSE_STYLE)) i_seq (
    .clk           (clk),
    .rst_n         (srst_n),
    .cfg_update_i  (cfg_update_i),
    .scan_done_i   (scan_done_i),
    .pll_rst_req_i (pll_rst_req_i),
    .busy_o        (busy_o),
    .done_pulse_o  (done_pulse_o),
    .pll_rst_o     (pll_rst_o)
  );

  upd_readback i_readback (
    .clk        (clk),
    .rst_n      (srst_n),
    .rcfg_req_i (rcfg_req_i),
    .scan_rd_i  (scan_rd_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  generate
    if (PULSE_STYLE) begin : g_pulse_status
      assign done_level_o = done_pulse_o;
    end else begin : g_level_status
      assign done_level_o = ~busy_o;
    end
  endgenerate

endmodule

// File: rtl/upd_tracker_chk.sv
module upd_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_update_i,
  input logic scan_done_i,
  input logic pll_rst_req_i,
  input logic rcfg_req_i,
  input logic scan_rd_i,
  input logic busy_o,
  input logic done_pulse_o,
  input logic pll_rst_o,
  input logic rd_valid_o,
  input logic rd_data_o
);

  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && cfg_update_i && !pll_rst_req_i) |=> busy_o);

  p_done_after_sd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse_o |-> $past(scan_done_i));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse_o |=> !done_pulse_o);

  p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse_o |-> $fell(busy_o));

  p_pll_rst_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pll_rst_o == $past(pll_rst_req_i)));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst_req_i |=> (!busy_o && !done_pulse_o));

  p_rd_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_valid_o == $past(rcfg_req_i)));

  p_rd_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_data_o == $past(scan_rd_i & rcfg_req_i)));

endmodule

bind pll_update_tracker upd_tracker_chk i_chk (
  .clk           (clk),
  .rst_n         (srst_n),
  .cfg_update_i  (cfg_update_i),
  .scan_done_i   (scan_done_i),
  .pll_rst_req_i (pll_rst_req_i),
  .rcfg_req_i    (rcfg_req_i),
  .scan_rd_i     (scan_rd_i),
  .busy_o        (busy_o),
  .done_pulse_o  (done_pulse_o),
  .pll_rst_o     (pll_rst_o),
  .rd_valid_o    (rd_valid_o),
  .rd_data_o     (rd_data_o)
);

// File: tb/test_pll_update_tracker.sv
module test_pll_update_tracker;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_l, cfg_p, sd_l, sd_p, req, rcfg, rd;
  logic busy_l, done_l, dlev_l, prst_l, rv_l, rdat_l;
  logic busy_p, done_p, dlev_p, prst_p, rv_p, rdat_p;
  int   total = 0;
  int   bad   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pll_update_tracker #(.PULSE_STYLE(1'b0)) i_pll_update_tracker (
    .clk(clk), .rst_n(rst_n), .cfg_update_i(cfg_l), .scan_done_i(sd_l),
    .pll_rst_req_i(req), .rcfg_req_i(rcfg), .scan_rd_i(rd),
    .busy_o(busy_l), .done_pulse_o(done_l), .done_level_o(dlev_l),
    .pll_rst_o(prst_l), .rd_valid_o(rv_l), .rd_data_o(rdat_l));

  pll_update_tracker #(.PULSE_STYLE(1'b1)) i_pll_update_tracker_pulse (
    .clk(clk), .rst_n(rst_n), .cfg_update_i(cfg_p), .scan_done_i(sd_p),
    .pll_rst_req_i(req), .rcfg_req_i(rcfg), .scan_rd_i(rd),
    .busy_o(busy_p), .done_pulse_o(done_p), .done_level_o(dlev_p),
    .pll_rst_o(prst_p), .rd_valid_o(rv_p), .rd_data_o(rdat_p));

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_l = 1'b0; cfg_p = 1'b0; sd_l = 1'b1; sd_p = 1'b0;
    req = 1'b0; rcfg = 1'b0; rd = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 busy_l in reset", busy_l, 1'b0);
    chk("R1 busy_p in reset", busy_p, 1'b0);
    chk("R1 pll_rst in reset", prst_l, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    chk("R1 busy_l", busy_l, 1'b0);
    chk("R1 done_l", done_l, 1'b0);
    chk("R1 done_p", done_p, 1'b0);
    chk("R1 pll_rst_l", prst_l, 1'b0);
    chk("R1 pll_rst_p", prst_p, 1'b0);
    chk("R1 rd_valid", rv_l, 1'b0);
    chk("R1 rd_data", rdat_l, 1'b0);
    chk("R7 level idle status", dlev_l, 1'b1);
    chk("R7 pulse idle status", dlev_p, 1'b0);

    // Level style sweep: scan-done stays high for a sets, then low for b sets
    for (int a = 0; a <= 5; a++) begin
      for (int b = 1; b <= 5; b++) begin
        for (int k = 0; k <= a + b + 4; k++) begin
          logic eb, ed;
          eb = (k >= 1) && (k <= a + b + 1);
          ed = (k == a + b + 2);
          @(negedge clk);
          if (k == 1)            chk("R2 level busy start", busy_l, eb);
          else if (k <= a + 1)   chk("R3 level no early done", busy_l, eb);
          else                   chk("R4 level busy", busy_l, eb);
          chk("R4 level done pulse", done_l, ed);
          chk("R7 level status", dlev_l, ~eb);
          cfg_l = (k == 0);
          sd_l  = !((k >= a + 1) && (k <= a + b));
        end
      end
    end

    // Pulse style sweep: scan-done high for one set at c
    for (int c = 1; c <= 8; c++) begin
      for (int k = 0; k <= c + 3; k++) begin
        logic eb, ed;
        eb = (k >= 1) && (k <= c);
        ed = (k == c + 1);
        @(negedge clk);
        if (k == 1) chk("R2 pulse busy start", busy_p, eb);
        else        chk("R5 pulse busy", busy_p, eb);
        chk("R5 pulse done", done_p, ed);
        chk("R7 pulse status", dlev_p, ed);
        cfg_p = (k == 0);
        sd_p  = (k == c);
      end
    end

    // R6: scan-done activity while idle gives no pulse
    @(negedge clk); sd_p = 1'b1; sd_l = 1'b0;
    @(negedge clk); sd_p = 1'b0; sd_l = 1'b1;
    chk("R6 pulse idle sd", done_p, 1'b0);
    chk("R6 pulse idle busy", busy_p, 1'b0);
    @(negedge clk);
    chk("R6 level idle sd", done_l, 1'b0);
    chk("R6 level idle busy", busy_l, 1'b0);

    // R8/R9: abort by reset request during a level update
    for (int m = 1; m <= 3; m++) begin
      for (int k = 0; k <= m + 6; k++) begin
        @(negedge clk);
        chk("R9 abort busy", busy_l, (k >= 1) && (k <= m));
        chk("R9 abort no done", done_l, 1'b0);
        chk("R8 pll_rst follows req", prst_l, (k == m + 1));
        chk("R8 pll_rst follows req pulse inst", prst_p, (k == m + 1));
        cfg_l = (k == 0);
        req   = (k == m);
        sd_l  = !((k >= 1) && (k <= m + 2));
      end
    end

    // R9: update sampled together with reset request is ignored
    @(negedge clk); cfg_l = 1'b1; cfg_p = 1'b1; req = 1'b1;
    @(negedge clk); cfg_l = 1'b0; cfg_p = 1'b0; req = 1'b0;
    chk("R9 cfg ignored level", busy_l, 1'b0);
    chk("R9 cfg ignored pulse", busy_p, 1'b0);
    chk("R8 pll_rst high", prst_l, 1'b1);
    @(negedge clk);
    chk("R8 pll_rst low", prst_l, 1'b0);
    chk("R9 still idle", busy_l, 1'b0);

    // R10: readback qualification, all input combinations
    for (int j = 0; j <= 4; j++) begin
      @(negedge clk);
      if (j > 0) begin
        chk("R10 rd_valid", rv_l, rcfg);
        chk("R10 rd_data", rdat_l, rcfg & rd);
        chk("R10 rd_data pulse inst", rdat_p, rcfg & rd);
      end
      rcfg = (j == 2) || (j == 3);
      rd   = (j == 1) || (j == 3);
    end
    @(negedge clk);
    chk("R10 rd_valid final", rv_l, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule